// File: doc/BRIEF.md
# PWM Channel with Selectable Shutdown

This block produces one pulse-width-modulated output from a single system clock. A 6-bit prescaler turns the system clock into a one-cycle tick enable. A period counter advances on each tick. The output is high while that counter is below a programmed duty value, and low for the rest of the period. A full-duty flag keeps the output high for the whole period.

The channel runs while its enable input is high. When the enable falls, a control bit picks one of two stop behaviours:
- **Graceful:** the period in progress runs to its end, then the output goes low.
- **Abrupt:** both counters go back to their reload values at once and the output drops on the next cycle.

Software programs three word-wide registers through a simple write port and reads them back through a combinational read port. Duty and period changes take effect only at a period boundary, so a write never cuts a pulse short or stretches it.

Top module: `pwm_chan`

## Requirements
- R1: After reset, every register reads 0 and `pwm_out` is low. The default setting is therefore divide-by-1 and graceful stop.
- R2: While the channel runs, each step of the period counter lasts exactly prescale+1 system clocks. The prescale field is control bits [5:0], with a range of 0..63.
- R3: One PWM period is period+1 counter steps, with the counter going 0..period. The output is high while the counter is below the duty value and low otherwise. The duty value is duty bits [9:0] and the period is period bits [9:0].
- R4: When the full-duty flag (duty bit 10) is set, the output is high for the whole period, whatever the duty value.
- R5: The register addresses are control = 0, duty = 1 and period = 2. Control bit 6 selects the stop mode: 0 is graceful and 1 is abrupt. Bits that have no field read as 0, and address 3 reads 0.
- R6: Duty, full-duty and period writes made during a period do not change that period. They are applied at the next period boundary, or when the channel starts.
- R7: In graceful mode, after the enable is sampled low, the output keeps following the waveform until the current period ends. The output then stays low.
- R8: In abrupt mode, the output is low from the first cycle after the enable is sampled low, and the counters return to their reload values.
- R9: While the channel is stopped, the output is low. Raising the enable starts a new period at counter value 0, with the prescaler freshly loaded.
- R10: If the enable returns high during a graceful wind-down, the channel keeps running without restarting its period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| chan_en | input | 1 | Channel enable; clearing it starts the selected stop |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 32 | Register read data (combinational) |
| pwm_out | output | 1 | PWM output |

## Verification
The bench targets these corner cases, each with the failure it would expose:
- **Write landing mid-period.** A design that loaded new values at once would show a clipped or stretched pulse in the current period.
- **Enable dropped during the high phase.** In graceful mode, a wrong design would cut the pulse. In abrupt mode, a wrong design would let the output linger after the stop.
- **Enable restored during a wind-down.** A design that restarted here would show a period that begins again at count 0.
- **Full-duty flag, prescale 0, and a duty value above the period.** These expose off-by-one errors in the tick spacing and in the duty compare.
- **Readback after all-ones writes.** This shows whether any bit that has no field was stored.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

  localparam int PS_W   = 6;
  localparam int SD_BIT = 6;

  localparam logic [1:0] ADDR_CTRL   = 2'd0;
  localparam logic [1:0] ADDR_DUTY   = 2'd1;
  localparam logic [1:0] ADDR_PERIOD = 2'd2;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DRAIN = 2'd2
  } pwm_state_e;

endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_pkg::*;
#(
  parameter int CNT_W = 10,
  parameter int DW    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [DW-1:0]    wr_data,
  input  logic [1:0]       rd_addr,
  output logic [DW-1:0]    rd_data,
  output logic [PS_W-1:0]  prescale,
  output logic             abrupt,
  output logic [CNT_W-1:0] duty,
  output logic             full,
  output logic [CNT_W-1:0] period
);

  logic [PS_W-1:0]  ps_q,   ps_d;
  logic             sd_q,   sd_d;
  logic [CNT_W-1:0] duty_q, duty_d;
  logic             full_q, full_d;
  logic [CNT_W-1:0] per_q,  per_d;
  logic             ctrl_we, duty_we, per_we;

  assign ctrl_we = wr_en && (wr_addr == ADDR_CTRL);
  assign duty_we = wr_en && (wr_addr == ADDR_DUTY);
  assign per_we  = wr_en && (wr_addr == ADDR_PERIOD);

  always_comb begin
    ps_d   = ps_q;
    sd_d   = sd_q;
    duty_d = duty_q;
    full_d = full_q;
    per_d  = per_q;
    if (ctrl_we) begin
      ps_d = wr_data[PS_W-1:0];
      sd_d = wr_data[SD_BIT];
    end
    if (duty_we) begin
      duty_d = wr_data[CNT_W-1:0];
      full_d = wr_data[CNT_W];
    end
    if (per_we) begin
      per_d = wr_data[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ps_q   <= '0;
      sd_q   <= 1'b0;
      duty_q <= '0;
      full_q <= 1'b0;
      per_q  <= '0;
    end else begin
      ps_q   <= ps_d;
      sd_q   <= sd_d;
      duty_q <= duty_d;
      full_q <= full_d;
      per_q  <= per_d;
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      ADDR_CTRL: begin
        rd_data[PS_W-1:0] = ps_q;
        rd_data[SD_BIT]   = sd_q;
      end
      ADDR_DUTY: begin
        rd_data[CNT_W-1:0] = duty_q;
        rd_data[CNT_W]     = full_q;
      end
      ADDR_PERIOD: rd_data[CNT_W-1:0] = per_q;
      default:     rd_data = '0;
    endcase
  end

  assign prescale = ps_q;
  assign abrupt   = sd_q;
  assign duty     = duty_q;
  assign full     = full_q;
  assign period   = per_q;

  // R5: a control write lands the mode bit from data bit 6
  p_ctrl_mode_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we |=> (abrupt == $past(wr_data[SD_BIT])));

endmodule

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
  import pwm_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run_q,
  input  logic            run_nxt,
  input  logic [PS_W-1:0] prescale,
  output logic            tick
);

  logic [PS_W-1:0] cnt_q, cnt_d;
  logic            reload;

  assign tick   = run_q && (cnt_q == '0);
  assign reload = !run_q || !run_nxt || tick;

  always_comb begin
    if (reload) cnt_d = prescale;
    else        cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R2: with a non-zero divisor setting, ticks are never back to back
  p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && prescale != '0) |=> !tick);

endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_q,
  input  logic             run_nxt,
  input  logic             tick,
  input  logic [CNT_W-1:0] duty,
  input  logic             full,
  input  logic [CNT_W-1:0] period,
  output logic             period_end,
  output logic             pwm_out
);

  logic [CNT_W-1:0] cnt_q,  cnt_d;
  logic [CNT_W-1:0] dact_q, dact_d;
  logic [CNT_W-1:0] pact_q, pact_d;
  logic             fact_q, fact_d;
  logic             load;

  assign period_end = tick && (cnt_q == pact_q);
  assign load       = run_nxt && (!run_q || period_end);

  always_comb begin
    cnt_d  = cnt_q;
    dact_d = dact_q;
    pact_d = pact_q;
    fact_d = fact_q;
    if (!run_nxt) begin
      cnt_d = '0;
    end else if (load) begin
      cnt_d  = '0;
      dact_d = duty;
      pact_d = period;
      fact_d = full;
    end else if (tick) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      dact_q <= '0;
      pact_q <= '0;
      fact_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      dact_q <= dact_d;
      pact_q <= pact_d;
      fact_q <= fact_d;
    end
  end

  assign pwm_out = run_q && (fact_q || (cnt_q < dact_q));

  // R3: the counter never passes the active period value
  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= pact_q);

  // R6: active duty and period hold between boundaries
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && run_nxt && !period_end) |=> ($stable(dact_q) && $stable(pact_q) && $stable(fact_q)));

endmodule

// File: rtl/pwm_ctrl.sv
module pwm_ctrl
  import pwm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic chan_en,
  input  logic abrupt,
  input  logic period_end,
  output logic run_q,
  output logic run_nxt
);

  pwm_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: begin
        if (chan_en) state_d = ST_RUN;
      end
      ST_RUN: begin
        if (!chan_en) state_d = abrupt ? ST_IDLE : ST_DRAIN;
      end
      ST_DRAIN: begin
        if (chan_en)         state_d = ST_RUN;
        else if (period_end) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign run_q   = (state_q != ST_IDLE);
  assign run_nxt = (state_d != ST_IDLE);

  // R8: an abrupt stop leaves no running cycle behind
  p_abrupt_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && !chan_en && abrupt) |=> (state_q == ST_IDLE));

  // R7: a graceful wind-down keeps running until the period ends
  p_drain_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DRAIN && !chan_en && !period_end) |=> (state_q == ST_DRAIN));

endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
  import pwm_pkg::*;
#(
  parameter int CNT_W = 10,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          chan_en,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [1:0]    rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          pwm_out
);

  logic             sync1_q, sync2_q;
  logic             rst_i_n;
  logic [PS_W-1:0]  prescale;
  logic             abrupt;
  logic [CNT_W-1:0] duty;
  logic             full;
  logic [CNT_W-1:0] period;
  logic             run_q, run_nxt, tick, period_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
    end else begin
      sync1_q <= 1'b1;
      sync2_q <= sync1_q;
    end
  end
  assign rst_i_n = sync2_q;

  pwm_regs #(.CNT_W(CNT_W), .DW(DW)) regs_i (
    .clk(clk), .rst_n(rst_i_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .prescale(prescale), .abrupt(abrupt), .duty(duty), .full(full),
    .period(period)
  );

  pwm_ctrl ctrl_i (
    .clk(clk), .rst_n(rst_i_n), .chan_en(chan_en), .abrupt(abrupt),
    .period_end(period_end), .run_q(run_q), .run_nxt(run_nxt)
  );

  pwm_prescaler pre_i (
    .clk(clk), .rst_n(rst_i_n), .run_q(run_q), .run_nxt(run_nxt),
    .prescale(prescale), .tick(tick)
  );

  pwm_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk(clk), .rst_n(rst_i_n), .run_q(run_q), .run_nxt(run_nxt),
    .tick(tick), .duty(duty), .full(full), .period(period),
    .period_end(period_end), .pwm_out(pwm_out)
  );

  // R9: a stopped channel drives its output low
  p_idle_low_r9: assert property (@(posedge clk) disable iff (!rst_i_n)
    !run_q |-> !pwm_out);

endmodule

// File: tb/pwm_chan_tb_top.sv
module pwm_chan_tb_top;

  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        chan_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        pwm_out;

  int n_checks = 0;
  int n_fail   = 0;
  string cur_req = "R1";
  bit model_on = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_chan dut_i (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .pwm_out(pwm_out)
  );

  // behavioural reference model
  int m_mode;              // 0 stopped, 1 running, 2 winding down
  int m_wait, m_step;
  int m_dact, m_pact;
  bit m_fact;
  int m_psc, m_duty, m_per;
  bit m_sd, m_full;
  bit m_s1, m_s2;

  task automatic m_restart();
    m_wait = m_psc;
    m_step = 0;
  endtask

  task automatic m_advance(bit tk, bit pe);
    if (tk) begin
      m_wait = m_psc;
      if (pe) begin
        m_step = 0; m_dact = m_duty; m_pact = m_per; m_fact = m_full;
      end else m_step++;
    end else m_wait--;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_wait = 0; m_step = 0; m_dact = 0; m_pact = 0; m_fact = 0;
      m_psc = 0; m_duty = 0; m_per = 0; m_sd = 0; m_full = 0;
      m_s1 = 0; m_s2 = 0;
    end else if (!m_s2) begin
      m_s2 = m_s1; m_s1 = 1'b1;
    end else begin
      bit tk, pe;
      tk = (m_mode != 0) && (m_wait == 0);
      pe = tk && (m_step == m_pact);
      case (m_mode)
        0: begin
          m_restart();
          if (chan_en) begin
            m_mode = 1; m_dact = m_duty; m_pact = m_per; m_fact = m_full;
          end
        end
        1: begin
          if (!chan_en && m_sd) begin m_mode = 0; m_restart(); end
          else begin
            if (!chan_en) m_mode = 2;
            m_advance(tk, pe);
          end
        end
        default: begin
          if (chan_en) begin m_mode = 1; m_advance(tk, pe); end
          else if (pe) begin m_mode = 0; m_restart(); end
          else m_advance(tk, pe);
        end
      endcase
      if (wr_en) begin
        case (wr_addr)
          2'd0: begin m_psc = wr_data[5:0]; m_sd = wr_data[6]; end
          2'd1: begin m_duty = wr_data[9:0]; m_full = wr_data[10]; end
          2'd2: m_per = wr_data[9:0];
          default: ;
        endcase
      end
    end
  end

  function automatic bit m_out();
    return (m_mode != 0) && (m_fact || (m_step < m_dact));
  endfunction

  task automatic check(string req, int act, int exp, string what);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (model_on) check(cur_req, pwm_out, m_out(), "pwm_out vs model");
  end

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk); #1;
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd_check(string req, logic [1:0] a, int exp);
    rd_addr = a; #1;
    check(req, rd_data, exp, "readback");
  endtask

  task automatic set_en(bit v);
    @(negedge clk); #1;
    chan_en = v;
  endtask

  task automatic cycles(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // length of the next high pulse, in clocks
  task automatic high_len(output int len);
    int guard = 0;
    len = 0;
    @(negedge clk);
    while (pwm_out && guard < 5000) begin @(negedge clk); guard++; end
    while (!pwm_out && guard < 5000) begin @(negedge clk); guard++; end
    while (pwm_out && guard < 5000) begin @(negedge clk); len++; guard++; end
  endtask

  // clocks between two rising edges
  task automatic rise_gap(output int gap);
    int guard = 0;
    gap = 0;
    @(negedge clk);
    while (pwm_out && guard < 5000) begin @(negedge clk); guard++; end
    while (!pwm_out && guard < 5000) begin @(negedge clk); guard++; end
    @(negedge clk); gap = 1;
    while (pwm_out && guard < 5000) begin @(negedge clk); gap++; guard++; end
    while (!pwm_out && guard < 5000) begin @(negedge clk); gap++; guard++; end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    model_on = 1'b1;

    // R1 reset state
    cur_req = "R1";
    rd_check("R1", 2'd0, 0);
    rd_check("R1", 2'd1, 0);
    rd_check("R1", 2'd2, 0);
    check("R1", pwm_out, 0, "output after reset");

    // R5 field layout, bits without a field read zero
    cur_req = "R5";
    wr(2'd0, 32'hFFFF_FFFF);
    wr(2'd1, 32'hFFFF_FFFF);
    wr(2'd2, 32'hFFFF_FFFF);
    wr(2'd3, 32'hFFFF_FFFF);
    rd_check("R5", 2'd0, 32'h7F);
    rd_check("R5", 2'd1, 32'h7FF);
    rd_check("R5", 2'd2, 32'h3FF);
    rd_check("R5", 2'd3, 0);

    // R9 stopped output low, start from count 0
    cur_req = "R9";
    wr(2'd0, 32'd3);          // divide by 4, graceful
    wr(2'd1, 32'd2);
    wr(2'd2, 32'd4);
    cycles(3);
    check("R9", pwm_out, 0, "output while stopped");
    set_en(1'b1);
    @(negedge clk);
    check("R9", pwm_out, 1, "output in first cycle of run");

    // R2 R3 pulse and period lengths
    cur_req = "R3";
    high_len(v);
    check("R2", v, 8, "high length duty 2 prescale 3");
    rise_gap(v);
    check("R3", v, 20, "period length period 4 prescale 3");

    // R6 mid-period write waits for the boundary
    cur_req = "R6";
    wr(2'd1, 32'd4);
    wr(2'd0, 32'd0);
    cycles(40);
    high_len(v);
    check("R6", v, 4, "high length after update, prescale 0");

    // R4 full-duty flag
    cur_req = "R4";
    wr(2'd1, 32'h400);
    cycles(12);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      check("R4", pwm_out, 1, "full duty output");
    end
    wr(2'd1, 32'd9);          // duty above period
    cycles(12);
    check("R3", pwm_out, 1, "duty above period stays high");

    // R7 graceful wind-down
    cur_req = "R7";
    wr(2'd1, 32'd2);
    wr(2'd0, 32'd2);          // divide by 3, graceful
    cycles(30);
    set_en(1'b0);
    cycles(20);
    check("R7", pwm_out, 0, "low after wind-down");

    // R10 enable restored during wind-down
    cur_req = "R10";
    set_en(1'b1);
    cycles(20);
    set_en(1'b0);
    cycles(2);
    set_en(1'b1);
    cycles(30);

    // R8 abrupt stop
    cur_req = "R8";
    wr(2'd0, 32'h45);         // abrupt, divide by 6
    cycles(40);
    while (!pwm_out) @(negedge clk);
    #1; chan_en = 1'b0;
    @(negedge clk);
    check("R8", pwm_out, 0, "low one cycle after abrupt stop");
    cycles(5);
    set_en(1'b1);
    @(negedge clk);
    check("R8", pwm_out, 1, "restart after abrupt stop begins high");
    cycles(60);

    model_on = 1'b0;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule